// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Shared Candidate Logic

This block is a purely combinational two-operand adder with a carry input. It is sized for a 32-bit datapath by default. The operand bits are split into carry-select groups whose widths grow from the least significant end, so the selection chain and the longest in-group ripple stay roughly balanced.

Each group works out its result twice, once assuming its incoming carry is 0 and once assuming it is 1. One XOR per bit is shared by both outcomes, and a gate pair per bit builds the carry candidates. There are no duplicated ripple adders. When the real carry reaches a group, multiplexers pick that group's sum bits and its carry-out. With the default width the group sizes are 2, 2, 3, 4, 5, 6, 7 and 3, and the lowest group takes the external carry-in.

It is meant to sit inside an arithmetic unit or a multiply-accumulate datapath. Its output is read in the same cycle that its inputs are presented.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every operand pair and carry-in, the concatenation {cout_o, sum_o} equals a_i + b_i + cin_i evaluated at WIDTH+1 bits, with cout_o being bit WIDTH of that total.
- R2: With both operands zero and cin_i = 0, sum_o is zero and cout_o is 0.
- R3: With a_i all ones, b_i zero and cin_i = 1, the carry ripples through every group: sum_o is zero and cout_o is 1.
- R4: When both operands are all ones, cout_o is 1 for either value of cin_i, and sum_o is all ones minus one plus cin_i.
- R5: A carry entering a group boundary from below selects that group's carry-in-1 outcome. For each group base position p (0, 2, 4, 7, 11, 16, 22, 29 with the default width), a_i = 2^p - 1, b_i = 0 and cin_i = 1 gives sum_o = 2^p.
- R6: A carry generated by the top bit of a group reaches the next group. For each group top position q (1, 3, 6, 10, 15, 21, 28), a_i = b_i = 2^q gives sum_o = 2^(q+1) and cout_o = 0.
- R7: With the operands held, raising cin_i from 0 to 1 raises the WIDTH+1-bit result {cout_o, sum_o} by exactly one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| cin_i | input | 1 | Carry into the least significant bit |
| sum_o | output | WIDTH | Low WIDTH bits of the total |
| cout_o | output | 1 | Bit WIDTH of the total |

## Verification
The assertions are immediate checks on combinational values, so they take for granted that every input bit is a defined 0 or 1 whenever they evaluate. They do not look at partially settled values. The stimulus drives all three inputs together from a task, one clock phase before anything is sampled, and it never leaves any input undriven. Apart from these assumptions, the candidate-ordering and candidate-step checks hold for any operand values. The directed and pseudo-random patterns therefore only aim to reach every group boundary, both carry-in values and the all-ones corners.

// File: rtl/csa_pkg.sv
package csa_pkg;

   // Nominal width of group k: two groups of 2, then growing by one.
   function automatic int nominal_size(input int k);
      return (k < 2) ? 2 : k + 1;
   endfunction

   // Number of groups needed to cover w bits.
   function automatic int grp_count(input int w);
      int used;
      int n;
      used = 0;
      n = 0;
      while (used < w) begin
         used += nominal_size(n);
         n++;
      end
      return n;
   endfunction

   // Position of the lowest bit of group k.
   function automatic int grp_base(input int w, input int k);
      int base;
      base = 0;
      for (int j = 0; j < k; j++) base += nominal_size(j);
      return (base > w) ? w : base;
   endfunction

   // Actual width of group k, with the last group truncated.
   function automatic int grp_size(input int w, input int k);
      int rem;
      rem = w - grp_base(w, k);
      return (nominal_size(k) < rem) ? nominal_size(k) : rem;
   endfunction

endpackage

// File: rtl/csa_bit_cell.sv
module csa_bit_cell (
   input  logic a_i,
   input  logic b_i,
   input  logic ci0_i,
   input  logic ci1_i,
   output logic s0_o,
   output logic s1_o,
   output logic c0_o,
   output logic c1_o
);
   logic prop, gen;

   assign prop = a_i ^ b_i;
   assign gen  = a_i & b_i;

   // One shared propagate term feeds both candidate chains.
   assign s0_o = prop ^ ci0_i;
   assign s1_o = prop ^ ci1_i;
   assign c0_o = gen | (prop & ci0_i);
   assign c1_o = gen | (prop & ci1_i);
endmodule

// File: rtl/csa_group.sv
module csa_group #(
   parameter int N = 4
) (
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   input  logic         csel_i,
   output logic [N-1:0] sum_o,
   output logic         cout_o
);
   localparam int CHAIN = N + 1;

   logic [N-1:0]     s0, s1;
   logic [CHAIN-1:0] c0, c1;

   generate
      if (N < 1) begin : g_bad_size
         $error("csa_group: N must be at least 1");
      end
   endgenerate

   assign c0[0] = 1'b0;
   assign c1[0] = 1'b1;

   generate
      for (genvar k = 0; k < N; k++) begin : g_bit
         if (k == 0) begin : g_head
            // Carry-in is a known constant here: XOR and its inverse give
            // the sum pair, AND and OR give the carry pair.
            logic p;
            assign p     = a_i[0] ^ b_i[0];
            assign s0[0] = p;
            assign s1[0] = ~p;
            assign c0[1] = a_i[0] & b_i[0];
            assign c1[1] = a_i[0] | b_i[0];
         end else begin : g_body
            csa_bit_cell u_cell (
               .a_i  (a_i[k]),
               .b_i  (b_i[k]),
               .ci0_i(c0[k]),
               .ci1_i(c1[k]),
               .s0_o (s0[k]),
               .s1_o (s1[k]),
               .c0_o (c0[k+1]),
               .c1_o (c1[k+1])
            );
         end
      end
   endgenerate

   // Incoming group carry picks one of the two candidate results.
   assign sum_o  = csel_i ? s1 : s0;
   assign cout_o = csel_i ? c1[N] : c0[N];

   // The carry-in-1 chain can never be low where the carry-in-0 chain is high.
   always_comb begin
      for (int k = 1; k < CHAIN; k++) begin
         assert_cand_order_R3: assert (!(c0[k] && !c1[k]))
            else $error("carry candidates out of order at %0d", k);
      end
   end

   // The two candidate results must differ by exactly one.
   always_comb begin
      assert_cand_step_R5: assert ({c1[N], s1} == ({c0[N], s0} + 1'b1))
         else $error("candidate results are not one apart");
   end
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);
   localparam int NGRP = csa_pkg::grp_count(WIDTH);
   localparam int TOTW = WIDTH + 1;

   logic [NGRP:0] gcarry;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sqrt_csel_adder: WIDTH must be at least 2");
      end
   endgenerate

   assign gcarry[0] = cin_i;

   generate
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         localparam int BASE = csa_pkg::grp_base(WIDTH, g);
         localparam int SZ   = csa_pkg::grp_size(WIDTH, g);
         csa_group #(.N(SZ)) u_grp (
            .a_i   (a_i[BASE +: SZ]),
            .b_i   (b_i[BASE +: SZ]),
            .csel_i(gcarry[g]),
            .sum_o (sum_o[BASE +: SZ]),
            .cout_o(gcarry[g+1])
         );
      end
   endgenerate

   assign cout_o = gcarry[NGRP];

   // The full result matches the arithmetic sum.
   always_comb begin
      assert_total_R1: assert ({cout_o, sum_o} ==
                               ({1'b0, a_i} + {1'b0, b_i} + TOTW'(cin_i)))
         else $error("adder total mismatch");
   end

   // Two all-ones operands always overflow.
   always_comb begin
      if (&a_i && &b_i) begin
         assert_max_cout_R4: assert (cout_o)
            else $error("missing carry-out for all-ones operands");
      end
   end
endmodule

// File: tb/tb_sqrt_csel_adder.sv
module tb_sqrt_csel_adder;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic [W-1:0] a, b;
   logic         cin;
   logic [W-1:0] sum;
   logic         cout;
   int           checks = 0;
   int           errors = 0;

   always #4 clk = ~clk;

   sqrt_csel_adder #(.WIDTH(W)) dut (
      .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
   );

   task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
      @(posedge clk);
      a = x; b = y; cin = c;
      @(negedge clk);
   endtask

   task automatic expect_val(input string req, input logic [W:0] exp);
      checks++;
      if ({cout, sum} !== exp) begin
         errors++;
         $display("FAIL %s a=%h b=%h cin=%b got=%h exp=%h", req, a, b, cin, {cout, sum}, exp);
      end
   endtask

   function automatic logic [W:0] ref_sum(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
      return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
   endfunction

   task automatic t_zero_R2();
      drive('0, '0, 1'b0);
      expect_val("R2", '0);
   endtask

   task automatic t_full_ripple_R3();
      drive('1, '0, 1'b1);
      expect_val("R3", {1'b1, {W{1'b0}}});
      drive('0, '1, 1'b1);
      expect_val("R3", {1'b1, {W{1'b0}}});
   endtask

   task automatic t_max_R4();
      drive('1, '1, 1'b0);
      expect_val("R4", {1'b1, {(W-1){1'b1}}, 1'b0});
      drive('1, '1, 1'b1);
      expect_val("R4", {1'b1, {W{1'b1}}});
   endtask

   task automatic t_boundary_in_R5();
      int bases[8] = '{0, 2, 4, 7, 11, 16, 22, 29};
      foreach (bases[i]) begin
         logic [W-1:0] x;
         x = (W'(1) << bases[i]) - W'(1);
         drive(x, '0, 1'b1);
         expect_val("R5", {1'b0, W'(1) << bases[i]});
      end
   endtask

   task automatic t_boundary_gen_R6();
      int tops[7] = '{1, 3, 6, 10, 15, 21, 28};
      foreach (tops[i]) begin
         logic [W-1:0] x;
         x = W'(1) << tops[i];
         drive(x, x, 1'b0);
         expect_val("R6", {1'b0, W'(1) << (tops[i] + 1)});
      end
   endtask

   task automatic t_cin_step_R7();
      for (int i = 0; i < 40; i++) begin
         logic [W-1:0] x, y;
         logic [W:0]   lo;
         x = $urandom();
         y = $urandom();
         drive(x, y, 1'b0);
         lo = {cout, sum};
         drive(x, y, 1'b1);
         expect_val("R7", lo + 1'b1);
      end
   endtask

   task automatic t_random_R1();
      for (int i = 0; i < 2000; i++) begin
         logic [W-1:0] x, y;
         logic         c;
         x = $urandom();
         y = $urandom();
         c = 1'($urandom());
         if (i % 7 == 0) y = ~x;
         drive(x, y, c);
         expect_val("R1", ref_sum(x, y, c));
      end
   endtask

   initial begin
      a = '0; b = '0; cin = 1'b0;
      void'($urandom(11));
      t_zero_R2();
      t_full_ripple_R3();
      t_max_R4();
      t_boundary_in_R5();
      t_boundary_gen_R6();
      t_cin_step_R7();
      t_random_R1();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule